// File: doc/BRIEF.md
# Time-Code Pulse Width Classifier

This block turns the demodulated pulse train of a long-wave time-signal receiver into decoded bits. Each second the transmitter sends a high pulse whose length carries one data bit: about 100 ms for a zero and about 200 ms for a one. One pulse is left out at the end of every minute, so the gap between two pulse starts stretches from about one second to about two. The block times every interval with a 16-bit span counter that is fed by a power-of-two prescaler. It then sorts the count into a tolerance window and reports a bit, a minute marker or an error.

The receiver output first passes through a synchroniser and an edge detector. A rising edge starts a pulse and restarts the counter. The count read at the falling edge is the pulse width, which is compared only with the short and long windows. The count read at the next rising edge is the rise-to-rise period, which is compared only with the one-second and marker windows. The controller has three states. `ST_IDLE` is disarmed. `ST_HIGH` times a pulse. `ST_LOW` waits for the next pulse start.

The transitions are named as follows:
- arm: `ST_IDLE` to `ST_HIGH` on a rising edge.
- width check: `ST_HIGH` to `ST_LOW` on a falling edge.
- period check: `ST_LOW` to `ST_HIGH` on a rising edge.
- timeout: `ST_HIGH` or `ST_LOW` to `ST_IDLE` when the counter saturates.

The nominal counts and tolerances are parameters. The prescaler exponent is an input, so one build can serve several system clock rates.

Top module: `timecode_pulse_classifier`

## Requirements
- R1: If a pulse width count lies within the short window (NOM_SHORT ± TOL_SHORT), the block raises `bit_stb` with `bit_val` = 0. If it lies within the long window (NOM_LONG ± TOL_LONG), the block raises `bit_stb` with `bit_val` = 1.
- R2: A pulse width count outside both the short and long windows raises `err_stb` and does not raise `bit_stb`.
- R3: The span counter restarts from zero on every rising edge. A rise-to-rise count within NOM_SEC ± TOL_SEC raises no strobe.
- R4: The span counter advances once every 2^`psc_exp` clocks. With `psc_exp` = 1, every duration takes twice as many clocks to reach the same count.
- R5: A rise-to-rise count within NOM_MARK ± TOL_MARK raises `mark_stb`, and the next valid bit reports position 0.
- R6: If the counter reaches its all-ones value before the next edge, it holds there and `err_stb` pulses once. The block then disarms. While disarmed, falling edges are ignored. The next rising edge re-arms the block without any period check.
- R7: `bit_pos` gives the position of the reported bit. Positions count up by one for each valid bit since the last marker. A valid pulse that arrives after position LAST_IDX has been reported raises `err_stb` instead of a bit, and positions restart from 0.
- R8: `bit_stb`, `mark_stb` and `err_stb` are registered single-cycle pulses. At most one of them is high in any cycle.
- R9: A rise-to-rise count outside both the one-second and marker windows raises `err_stb`.
- R10: Synchronous reset clears the strobes, `bit_pos`, the position count and the armed state. The first rising edge after reset raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_in | input | 1 | Raw receiver output, asynchronous; high during a pulse |
| psc_exp | input | EXP_W | Prescaler exponent N; the counter ticks every 2^N clocks |
| bit_stb | output | 1 | One-cycle strobe: a valid data bit was decoded |
| bit_val | output | 1 | Value of the decoded bit (0 short, 1 long) |
| mark_stb | output | 1 | One-cycle strobe: minute-marker gap detected |
| err_stb | output | 1 | One-cycle strobe: out-of-window interval, timeout or position overrun |
| bit_pos | output | IDX_W | Position of the bit reported with `bit_stb` |

## Verification
The pulse train mixes short and long widths with one-second periods. This separates the two width windows from each other and shows that a normal period stays silent. A mid-length width, a 1.5-second period and a doubled period tell the error, marker and resynchronisation paths apart. Gaps and pulses held longer than the counter range show the saturate-and-disarm path, including a falling edge that must be ignored. The same train is repeated with exponent 1, once with doubled durations that must decode unchanged and once with undoubled widths that must now fail. A full minute of 59 bits followed by an extra pulse separates the position overrun from a normal marker.

// File: rtl/tcpc_pkg.sv
package tcpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } tcpc_state_e;

    localparam int NCLS      = 4;
    localparam int CLS_SHORT = 0;
    localparam int CLS_LONG  = 1;
    localparam int CLS_SEC   = 2;
    localparam int CLS_MARK  = 3;

endpackage

// File: rtl/tcpc_edge_sync.sv
module tcpc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              prev;

    if (STAGES > 1) begin : g_multi
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], din};
        end
    end else begin : g_single
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/tcpc_prescaler.sv
module tcpc_prescaler #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             tick
);

    localparam int PRE_W = (1 << EXP_W) - 1;

    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] mask;

    // low exp_sel bits of the free-running count must all be ones
    assign mask = ~({PRE_W{1'b1}} << exp_sel);
    assign tick = &(pcnt | ~mask);

    always_ff @(posedge clk) begin
        if (rst || restart) pcnt <= '0;
        else                pcnt <= pcnt + 1'b1;
    end

endmodule

// File: rtl/tcpc_interval_counter.sv
module tcpc_interval_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= CNT_MAX;
            ovf   <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (restart) begin
                count <= '0;
            end else if (tick && count != CNT_MAX) begin
                count <= count + 1'b1;
                ovf   <= (count == CNT_MAX - 1'b1);
            end
        end
    end

    assert_restart_zero_R3: assert property (@(posedge clk) disable iff (rst)
        restart |=> count == '0);

    assert_tick_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!restart && tick && count != CNT_MAX) |=> count == $past(count) + 1'b1);

    assert_hold_max_R6: assert property (@(posedge clk) disable iff (rst)
        (!restart && count == CNT_MAX) |=> count == CNT_MAX);

endmodule

// File: rtl/timecode_pulse_classifier.sv
module timecode_pulse_classifier
    import tcpc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int EXP_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int NOM_SHORT   = 2823,
    parameter int TOL_SHORT   = 280,
    parameter int NOM_LONG    = 5646,
    parameter int TOL_LONG    = 560,
    parameter int NOM_SEC     = 28230,
    parameter int TOL_SEC     = 1400,
    parameter int NOM_MARK    = 56463,
    parameter int TOL_MARK    = 2800,
    parameter int LAST_IDX    = 58,
    localparam int IDX_W      = $clog2(LAST_IDX + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_in,
    input  logic [EXP_W-1:0] psc_exp,
    output logic             bit_stb,
    output logic             bit_val,
    output logic             mark_stb,
    output logic             err_stb,
    output logic [IDX_W-1:0] bit_pos
);

    logic             rise, fall, tick, ovf;
    logic [CNT_W-1:0] cnt;
    logic [NCLS-1:0]  win_hit;

    tcpc_state_e      state, state_nxt;
    logic [IDX_W-1:0] seq_idx;
    logic             ev_bit, ev_val, ev_mark, ev_err, ev_wrap;

    tcpc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_in),
        .rise (rise),
        .fall (fall)
    );

    tcpc_prescaler #(.EXP_W(EXP_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .restart (rise),
        .exp_sel (psc_exp),
        .tick    (tick)
    );

    tcpc_interval_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (rise),
        .tick    (tick),
        .count   (cnt),
        .ovf     (ovf)
    );

    // one tolerance window per duration class
    for (genvar c = 0; c < NCLS; c++) begin : g_win
        localparam int NOM = (c == CLS_SHORT) ? NOM_SHORT :
                             (c == CLS_LONG)  ? NOM_LONG  :
                             (c == CLS_SEC)   ? NOM_SEC   : NOM_MARK;
        localparam int TOL = (c == CLS_SHORT) ? TOL_SHORT :
                             (c == CLS_LONG)  ? TOL_LONG  :
                             (c == CLS_SEC)   ? TOL_SEC   : TOL_MARK;
        localparam int LO  = (NOM > TOL) ? NOM - TOL : 0;
        localparam int HI  = NOM + TOL;
        assign win_hit[c] = (32'(cnt) >= 32'(LO)) && (32'(cnt) <= 32'(HI));
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // next state and event decode
    always_comb begin
        state_nxt = state;
        ev_bit    = 1'b0;
        ev_val    = 1'b0;
        ev_mark   = 1'b0;
        ev_err    = 1'b0;
        ev_wrap   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (rise) state_nxt = ST_HIGH;              // arm
            end
            ST_HIGH: begin
                if (fall) begin                              // width check
                    state_nxt = ST_LOW;
                    if (win_hit[CLS_SHORT] || win_hit[CLS_LONG]) begin
                        if (seq_idx > IDX_W'(LAST_IDX)) begin
                            ev_err  = 1'b1;
                            ev_wrap = 1'b1;
                        end else begin
                            ev_bit = 1'b1;
                            ev_val = !win_hit[CLS_SHORT];
                        end
                    end else begin
                        ev_err = 1'b1;
                    end
                end else if (ovf) begin                      // timeout
                    state_nxt = ST_IDLE;
                    ev_err    = 1'b1;
                end
            end
            ST_LOW: begin
                if (rise) begin                              // period check
                    state_nxt = ST_HIGH;
                    if (win_hit[CLS_SEC])       ev_mark = 1'b0;
                    else if (win_hit[CLS_MARK]) ev_mark = 1'b1;
                    else                        ev_err  = 1'b1;
                end else if (ovf) begin                      // timeout
                    state_nxt = ST_IDLE;
                    ev_err    = 1'b1;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // registered outputs and bit position
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_stb  <= 1'b0;
            bit_val  <= 1'b0;
            mark_stb <= 1'b0;
            err_stb  <= 1'b0;
            bit_pos  <= '0;
            seq_idx  <= '0;
        end else begin
            bit_stb  <= ev_bit;
            mark_stb <= ev_mark;
            err_stb  <= ev_err;
            if (ev_bit) begin
                bit_val <= ev_val;
                bit_pos <= seq_idx;
                seq_idx <= seq_idx + 1'b1;
            end else if (ev_mark) begin
                bit_pos <= '0;
                seq_idx <= '0;
            end else if (ev_wrap) begin
                seq_idx <= '0;
            end
        end
    end

    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bit_stb, mark_stb, err_stb}));

    assert_bit_single_R8: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);

    assert_pos_range_R7: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> bit_pos <= IDX_W'(LAST_IDX));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> (!bit_stb && !mark_stb));

endmodule

// File: tb/sim_timecode_pulse_classifier.sv
`timescale 1ns/1ps
module sim_timecode_pulse_classifier;

    localparam int CNT_W = 10;
    localparam int EXP_W = 4;
    localparam int N_S = 20,  T_S = 4;
    localparam int N_L = 40,  T_L = 4;
    localparam int N_P = 200, T_P = 10;
    localparam int N_M = 400, T_M = 10;
    localparam int LAST = 58;
    localparam int IDX_W = $clog2(LAST + 2);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx  = 1'b0;
    logic [EXP_W-1:0] psc = '0;
    logic bit_stb, bit_val, mark_stb, err_stb;
    logic [IDX_W-1:0] bit_pos;

    always #4 clk = ~clk;

    timecode_pulse_classifier #(
        .CNT_W(CNT_W), .EXP_W(EXP_W),
        .NOM_SHORT(N_S), .TOL_SHORT(T_S), .NOM_LONG(N_L), .TOL_LONG(T_L),
        .NOM_SEC(N_P), .TOL_SEC(T_P), .NOM_MARK(N_M), .TOL_MARK(T_M),
        .LAST_IDX(LAST)
    ) u0 (
        .clk(clk), .rst(rst), .rx_in(rx), .psc_exp(psc),
        .bit_stb(bit_stb), .bit_val(bit_val), .mark_stb(mark_stb),
        .err_stb(err_stb), .bit_pos(bit_pos)
    );

    typedef struct {
        int    kind;   // 0 bit, 1 marker, 2 error
        int    val;
        int    pos;
        string req;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0, n_bad = 0, n_me = 0;
    bit reported = 1'b0;

    // bench model state
    int  n_exp = 0;
    bit  armed = 1'b0;
    int  prev_per = 0;
    int  idx = 0;

    function automatic int cls(int c);
        if (c >= N_S - T_S && c <= N_S + T_S) return 0;
        if (c >= N_L - T_L && c <= N_L + T_L) return 1;
        if (c >= N_P - T_P && c <= N_P + T_P) return 2;
        if (c >= N_M - T_M && c <= N_M + T_M) return 3;
        return -1;
    endfunction

    function automatic int ovf_cyc();
        return ((1 << CNT_W) - 1) << n_exp;
    endfunction

    task automatic push(int kind, int val, int pos, string req);
        exp_t e;
        e.kind = kind; e.val = val; e.pos = pos; e.req = req;
        q.push_back(e);
    endtask

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // driver: one pulse of hi clocks followed by lo clocks
    task automatic pulse(int hi, int lo);
        int c;
        bit was_armed = armed;
        bit per_quiet = 1'b0;
        string bit_req = (n_exp != 0) ? "R4" : "R1";
        int me0;
        if (armed) begin
            c = cls(prev_per >> n_exp);
            if (c == 2) per_quiet = 1'b1;                 // R3 silent second
            else if (c == 3) begin push(1, 0, 0, "R5"); idx = 0; end
            else push(2, 0, 0, "R9");
        end else begin
            armed = 1'b1;                                  // R10 / R6 re-arm
        end
        if (hi >= ovf_cyc()) begin
            push(2, 0, 0, "R6");
            armed = 1'b0;
        end else begin
            c = cls(hi >> n_exp);
            if (c == 0 || c == 1) begin
                if (idx > LAST) begin push(2, 0, 0, "R7"); idx = 0; end
                else begin push(0, c, idx, bit_req); idx++; end
            end else begin
                push(2, 0, 0, (n_exp != 0) ? "R4" : "R2");
            end
            if (hi + lo >= ovf_cyc()) begin push(2, 0, 0, "R6"); armed = 1'b0; end
        end
        prev_per = hi + lo;
        me0 = n_me;
        rx = 1'b1;
        repeat (hi) @(negedge clk);
        if (hi < ovf_cyc()) begin
            if (!was_armed)
                check(n_me == me0, "R10", "strobe on arming edge", n_me - me0, 0);
            else if (per_quiet)
                check(n_me == me0, "R3", "strobe on one-second period", n_me - me0, 0);
        end
        rx = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    // monitor: pops expected items as strobes appear
    bit pb = 1'b0, pm = 1'b0, pe = 1'b0;
    always @(negedge clk) begin
        int   k;
        exp_t e;
        if (!rst) begin
            if (bit_stb || mark_stb || err_stb) begin
                k = bit_stb ? 0 : (mark_stb ? 1 : 2);
                if (!bit_stb) n_me++;
                check($countones({bit_stb, mark_stb, err_stb}) == 1, "R8", "strobes at once",
                      $countones({bit_stb, mark_stb, err_stb}), 1);
                check(!((bit_stb && pb) || (mark_stb && pm) || (err_stb && pe)), "R8",
                      "strobe longer than one cycle", 2, 1);
                if (q.size() == 0) begin
                    check(1'b0, "R8", "unexpected strobe kind", k, -1);
                end else begin
                    e = q.pop_front();
                    check(k == e.kind, e.req, "strobe kind", k, e.kind);
                    if (k == 0 && e.kind == 0) begin
                        check(int'(bit_val) == e.val, e.req, "bit value", int'(bit_val), e.val);
                        check(int'(bit_pos) == e.pos, (e.pos == 0) ? "R5" : "R7",
                              "bit position", int'(bit_pos), e.pos);
                    end
                end
            end
            pb = bit_stb; pm = mark_stb; pe = err_stb;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check({bit_stb, mark_stb, err_stb} == 3'b000, "R10", "strobes after reset",
              int'({bit_stb, mark_stb, err_stb}), 0);
        check(bit_pos == '0, "R10", "bit_pos after reset", int'(bit_pos), 0);
        repeat (10) @(negedge clk);

        pulse(20, 180);     // arm, bit 0 (R10, R1)
        pulse(40, 160);     // one second silent, bit 1 (R3, R1)
        pulse(30, 170);     // width between windows (R2)
        pulse(20, 380);     // bit 0
        pulse(40, 160);     // marker gap then bit 1 at position 0 (R5)
        pulse(20, 280);     // bit 0
        pulse(20, 180);     // 1.5 s period error (R9)
        pulse(20, 1200);    // overflow in gap (R6)
        pulse(20, 180);     // silent re-arm then bit (R6)
        pulse(1100, 180);   // overflow during pulse, fall ignored (R6)

        n_exp = 1; psc = 4'd1;  // block is disarmed here
        pulse(40, 360);     // R4 doubled short
        pulse(80, 320);     // R4 doubled long
        pulse(20, 380);     // R4 undoubled width now too short
        pulse(40, 760);
        pulse(40, 360);     // doubled marker gap
        pulse(40, 2200);    // overflow to disarm
        n_exp = 0; psc = 4'd0;

        pulse(20, 180);
        pulse(20, 380);
        pulse(20, 180);     // marker, position 0
        for (int i = 1; i <= LAST; i++)
            pulse((i % 2) ? 40 : 20, (i % 2) ? 160 : 180);
        pulse(20, 180);     // position overrun (R7)
        pulse(40, 160);     // position restarts at 0
        repeat (20) @(negedge clk);

        check(q.size() == 0, "R8", "expected strobes still pending", q.size(), 0);
        finish_run();
    end

endmodule